// File: doc/BRIEF.md
# PWM Compare Channel with Deferred Update

This block is one compare channel of a PWM generator. It keeps a 16-bit threshold and compares it with the generator's running counter. When the two are equal, it raises a single-cycle `match` strobe. Downstream logic uses that strobe to toggle PWM outputs, raise an interrupt or start an ADC conversion. The counter, the period (load) register and the output-action logic all sit outside the block. They reach it only as the inputs `cnt_val`, `load_val` and `cnt_zero`.

Software writes a new threshold through a 32-bit write port. The value goes into a staging register and does not touch the comparison right away. The staged value is copied into the active threshold only on a cycle where `cnt_zero` is high. In immediate mode the copy happens at the first such cycle. In synchronous mode the copy also waits until a global update request has been seen. A staged value that is overwritten before it is copied is lost. A threshold larger than the period never produces a strobe.

The write port follows valid/ready rules, but `wr_ready` is always high, so there is no back-pressure. A write is taken on every clock edge where `wr_valid` is high, and the last write taken in a cycle wins.

Top module: `pwmc_compare_chan`

## Requirements
- R1: Only bits [15:0] of `wr_data` are stored. `rd_data[31:16]` always reads 0, and `wr_ready` is always 1.
- R2: `match` is registered. It goes high one clock after a cycle in which `cnt_val` equals the active threshold.
- R3: If the active threshold is greater than `load_val`, `match` stays low even when the counter equals the threshold.
- R4: With `upd_mode`=0 (immediate), a staged value becomes the active threshold at the first clock edge where `cnt_zero`=1. The active threshold never changes on any other edge.
- R5: With `upd_mode`=1 (synchronous), no copy happens at `cnt_zero` until `sync_req` has been seen.
  - A `sync_req` pulse is held in a sticky flag.
  - A `sync_req` in the same cycle as `cnt_zero` also counts.
  - The flag clears when a copy takes place.
- R6: If the staging register is written twice before a copy, the first value is never used.
- R7: After reset, both the staged and the active threshold are 0. `rd_data` reads 0 and `match` is low.
- R8: If the counter holds at a value equal to the threshold, only one `match` pulse is issued until equality is lost.
- R9: `rd_data` returns the most recently written value, not the active threshold.
- R10: Without a write since the last copy, a `cnt_zero` cycle leaves the active threshold unchanged, even in synchronous mode with a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for the staging register |
| wr_ready | output | 1 | Always 1: writes are taken every cycle |
| wr_data | input | 32 | Write data; only bits [15:0] are kept |
| rd_data | output | 32 | Staged value, zero-extended |
| cnt_val | input | 16 | Running counter value |
| load_val | input | 16 | Current period (load) value |
| cnt_zero | input | 1 | High in the cycle the counter is at zero |
| upd_mode | input | 1 | Update mode: 0 immediate, 1 synchronous |
| sync_req | input | 1 | Global synchronous-update request |
| match | output | 1 | One-cycle equality strobe |

## Verification
The comparison is driven with the counter moving through the threshold, holding on it, and standing on it while the period sits below the threshold. These patterns separate a real equality strobe from a repeated one and from one that should be suppressed. Threshold updates are applied in immediate mode, in synchronous mode with and without a request, with the request arriving early or in the same cycle as the zero event, and with no staged value at all. Each case is judged by when the strobe moves to the new threshold. Double writes, zero-extension and read-back of a staged value that is not yet active show that the staging register and the active register are kept apart.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  // Update-mode encoding shared by the control logic and the checker
  typedef enum logic {
    UPD_IMMED = 1'b0,
    UPD_SYNC  = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/pwmc_wr_port.sv
// Staging register: holds the latest software write until it is copied
module pwmc_wr_port #(
  parameter int REG_W = 32,
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [REG_W-1:0] wr_data,
  input  logic             xfer,
  output logic [CMP_W-1:0] pend_val,
  output logic             pend_vld,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - CMP_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_val <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (wr_valid) pend_val <= wr_data[CMP_W-1:0];
      // a write in the copy cycle re-arms the valid flag
      if (wr_valid)  pend_vld <= 1'b1;
      else if (xfer) pend_vld <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, pend_val};
    end else begin : g_nopad
      assign rd_data = pend_val[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pwmc_upd_ctl.sv
// Decides when the staged value becomes active and holds the active value
module pwmc_upd_ctl
  import pwmc_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_zero,
  input  logic             upd_mode,
  input  logic             sync_req,
  input  logic             pend_vld,
  input  logic [CMP_W-1:0] pend_val,
  output logic             xfer,
  output logic             sync_flag,
  output logic [CMP_W-1:0] active_val
);
  upd_mode_e mode;
  logic      sync_seen;

  assign mode      = upd_mode_e'(upd_mode);
  assign sync_seen = sync_flag | sync_req;

  always_comb begin
    xfer = 1'b0;
    if (cnt_zero && pend_vld) begin
      unique case (mode)
        UPD_IMMED: xfer = 1'b1;
        UPD_SYNC:  xfer = sync_seen;
        default:   xfer = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_flag  <= 1'b0;
      active_val <= '0;
    end else begin
      if (xfer)          sync_flag <= 1'b0;
      else if (sync_req) sync_flag <= 1'b1;
      if (xfer) active_val <= pend_val;
    end
  end
endmodule

// File: rtl/pwmc_match.sv
// Equality detector with a range guard and single-pulse output
module pwmc_match #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic [CMP_W-1:0] load_val,
  input  logic [CMP_W-1:0] active_val,
  output logic             match
);
  logic hit;
  logic hit_q;

  assign hit = (cnt_val == active_val) && (active_val <= load_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      match <= 1'b0;
    end else begin
      hit_q <= hit;
      match <= hit & ~hit_q;
    end
  end
endmodule

// File: rtl/pwmc_compare_chan.sv
module pwmc_compare_chan #(
  parameter int REG_W = 32,
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic [CMP_W-1:0] load_val,
  input  logic             cnt_zero,
  input  logic             upd_mode,
  input  logic             sync_req,
  output logic             match
);
  logic [CMP_W-1:0] pend_val;
  logic             pend_vld;
  logic             xfer;
  logic             sync_flag;
  logic [CMP_W-1:0] active_val;

  assign wr_ready = 1'b1;

  pwmc_wr_port #(.REG_W(REG_W), .CMP_W(CMP_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .xfer(xfer), .pend_val(pend_val), .pend_vld(pend_vld), .rd_data(rd_data)
  );

  pwmc_upd_ctl #(.CMP_W(CMP_W)) u_upd (
    .clk(clk), .rst_n(rst_n), .cnt_zero(cnt_zero), .upd_mode(upd_mode),
    .sync_req(sync_req), .pend_vld(pend_vld), .pend_val(pend_val),
    .xfer(xfer), .sync_flag(sync_flag), .active_val(active_val)
  );

  pwmc_match #(.CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .load_val(load_val),
    .active_val(active_val), .match(match)
  );
endmodule

// File: rtl/pwmc_compare_chan_chk.sv
module pwmc_compare_chan_chk #(
  parameter int REG_W = 32,
  parameter int CMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ready,
  input logic [REG_W-1:0] rd_data,
  input logic [CMP_W-1:0] cnt_val,
  input logic [CMP_W-1:0] load_val,
  input logic             cnt_zero,
  input logic             upd_mode,
  input logic             sync_req,
  input logic             match,
  input logic             pend_vld,
  input logic             sync_flag,
  input logic [CMP_W-1:0] active_val
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:CMP_W] == '0) && wr_ready);

  p_match_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ($past(cnt_val) == $past(active_val)));

  p_no_pulse_over_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ($past(active_val) <= $past(load_val)));

  p_act_only_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero |=> $stable(active_val));

  p_sync_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && upd_mode && !sync_flag && !sync_req) |=> $stable(active_val));

  p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !(match && $stable(cnt_val) && $stable(active_val)));

  p_no_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !pend_vld) |=> $stable(active_val));
endmodule

bind pwmc_compare_chan pwmc_compare_chan_chk #(.REG_W(REG_W), .CMP_W(CMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_data(rd_data),
  .cnt_val(cnt_val), .load_val(load_val), .cnt_zero(cnt_zero),
  .upd_mode(upd_mode), .sync_req(sync_req), .match(match),
  .pend_vld(pend_vld), .sync_flag(sync_flag), .active_val(active_val)
);

// File: tb/sim_pwmc_compare_chan.sv
module sim_pwmc_compare_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [15:0] cnt_val;
  logic [15:0] load_val;
  logic        cnt_zero;
  logic        upd_mode;
  logic        sync_req;
  logic        match;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  pwmc_compare_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .cnt_val(cnt_val),
    .load_val(load_val), .cnt_zero(cnt_zero), .upd_mode(upd_mode),
    .sync_req(sync_req), .match(match)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic [15:0] cnt;
    logic [15:0] load;
    logic        zero;
    logic        mode;
    logic        sreq;
    logic        exp;
  } vec_t;

  localparam int NV = 28;
  // wr, data, cnt, load, zero, mode, sreq, expected match after the edge
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'd5, 16'd3, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 0 stage 5
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b0, 1'b0, 1'b1}, // 1 R7 active 0 hits
    '{1'b0, 16'd0, 16'd1, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 2
    '{1'b0, 16'd0, 16'd5, 16'd10, 1'b0, 1'b0, 1'b0, 1'b1}, // 3 R2 R4
    '{1'b0, 16'd0, 16'd5, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 4 R8 hold
    '{1'b0, 16'd0, 16'd6, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 5
    '{1'b1, 16'd8, 16'd5, 16'd4,  1'b0, 1'b0, 1'b0, 1'b0}, // 6 R3 over load
    '{1'b1, 16'd9, 16'd7, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 7 R6 rewrite
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b0, 1'b0, 1'b0}, // 8 copy 9
    '{1'b0, 16'd0, 16'd8, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0}, // 9 R6 8 lost
    '{1'b0, 16'd0, 16'd9, 16'd10, 1'b0, 1'b0, 1'b0, 1'b1}, // 10 R6
    '{1'b1, 16'd3, 16'd10, 16'd10,1'b0, 1'b0, 1'b0, 1'b0}, // 11 stage 3
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b0, 1'b0}, // 12 R5 no req
    '{1'b0, 16'd0, 16'd9, 16'd10, 1'b0, 1'b0, 1'b0, 1'b1}, // 13 R5 still 9
    '{1'b0, 16'd0, 16'd2, 16'd10, 1'b0, 1'b1, 1'b1, 1'b0}, // 14 R5 request
    '{1'b0, 16'd0, 16'd9, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 15 R5 waits zero
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b0, 1'b0}, // 16 R5 copy 3
    '{1'b0, 16'd0, 16'd3, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 17 R5
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b1, 1'b0}, // 18 R10 nothing staged
    '{1'b0, 16'd0, 16'd3, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 19 R10 still 3
    '{1'b1, 16'd7, 16'd4, 16'd10, 1'b0, 1'b1, 1'b0, 1'b0}, // 20 stage 7
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b0, 1'b0}, // 21 R5 sticky flag
    '{1'b0, 16'd0, 16'd7, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 22 R5
    '{1'b1, 16'd2, 16'd1, 16'd10, 1'b0, 1'b1, 1'b0, 1'b0}, // 23 stage 2
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b1, 1'b0}, // 24 R5 same-cycle req
    '{1'b0, 16'd0, 16'd2, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}, // 25 R5
    '{1'b0, 16'd0, 16'd0, 16'd10, 1'b1, 1'b1, 1'b0, 1'b0}, // 26 flag cleared
    '{1'b0, 16'd0, 16'd2, 16'd10, 1'b0, 1'b1, 1'b0, 1'b1}  // 27 R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    wr_valid = v.wr;
    wr_data  = {16'h0, v.data};
    cnt_val  = v.cnt;
    load_val = v.load;
    cnt_zero = v.zero;
    upd_mode = v.mode;
    sync_req = v.sreq;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    drive('{1'b0, 16'd0, 16'd1, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0});
    step();
    step();
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R7 rd_data", rd_data, 32'h0);
    check("R7 match", {31'h0, match}, 32'h0);
    check("R1 wr_ready", {31'h0, wr_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      step();
      check($sformatf("R2..R10 vector %0d match", i), {31'h0, match}, {31'h0, TBL[i].exp});
    end

    // R1: upper half of the write is dropped
    wr_valid = 1'b1; wr_data = 32'hABCD_1234; cnt_val = 16'd4; cnt_zero = 1'b0;
    step();
    wr_valid = 1'b0;
    check("R1 zero-extend", rd_data, 32'h0000_1234);
    // R9: read-back shows staged value while active (2) still produces the strobe
    check("R9 read latest", rd_data, 32'h0000_1234);
    cnt_val = 16'd2;
    step();
    check("R9 active unchanged", {31'h0, match}, 32'h1);

    // R6 at the port: the second write replaces the first
    wr_valid = 1'b1; wr_data = 32'h0000_0011;
    step();
    wr_data = 32'h0000_0022;
    step();
    wr_valid = 1'b0;
    check("R6 read latest", rd_data, 32'h0000_0022);

    // R3 boundary: threshold equal to load still pulses
    upd_mode = 1'b0; cnt_zero = 1'b1; cnt_val = 16'd0;
    step();
    cnt_zero = 1'b0; load_val = 16'h22; cnt_val = 16'h22;
    step();
    check("R3 equal to load", {31'h0, match}, 32'h1);
    cnt_val = 16'h0; step();
    load_val = 16'h21; cnt_val = 16'h22;
    step();
    check("R3 above load", {31'h0, match}, 32'h0);

    // R7: reset mid-run clears both registers
    do_reset();
    check("R7 rd_data after reset", rd_data, 32'h0);
    cnt_val = 16'd0; load_val = 16'd0;
    step();
    check("R7 active zero", {31'h0, match}, 32'h1);
    step();
    check("R8 no repeat at zero", {31'h0, match}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule